// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how each register of a five-stage in-order instruction pipeline updates. It looks at the instruction classes held in the decode, execute and memory stages, at the two source register IDs in decode, at the load destination in execute and at the branch condition of the execute instruction. From these it finds three situations: a load whose result is needed at once by the next instruction, a conditional jump that was predicted taken but falls through, and a return whose target is not yet known. Each situation maps to a fixed set of per-stage actions. A stage can load normally, stall (hold its contents) or take a bubble (load a nop).

The controller is combinational. The stage registers act on its mode signals at the next rising clock edge. To make the control observable, the block wraps the controller in a pipeline skeleton. One parameterised stage register sits in each of decode, execute, memory and write-back, and each carries an instruction slot. The slot holds the class, the two source IDs, the load destination and an identifying tag. The fetch stage is the instruction source outside the block, and it must hold its word while fetch stall is asserted. A bubble slot has class nop, tag 0 and all register IDs set to the all-ones "no register" value.

Top module: `hazard_ctl_top`

## Requirements
- R1: While and directly after reset, every stage holds a nop slot (tag 0) and no mode output is asserted.
- R2: With no hazard present, the fetch slot enters decode at the next edge and then advances one stage per cycle through execute, memory and write-back.
- R3: A load/use hazard exists when the execute class is load (2) or pop (3), its load destination is not the all-ones ID (15 by default), and that destination equals the decode source A or source B ID.
- R4: On a load/use hazard, fetch and decode stall and execute takes a bubble. The dependent instruction waits in decode for exactly one cycle.
- R5: A misprediction exists when the execute class is jump (4) and the branch condition input is 0. A jump whose condition is 1 causes no action.
- R6: On a misprediction, decode and execute take bubbles and fetch is not stalled. The two instructions after the jump never reach write-back.
- R7: A return is in progress while class return (5) is held in decode, execute or memory.
- R8: While a return is in progress, fetch stalls and decode takes a bubble. An isolated return holds fetch for exactly three cycles and inserts three bubbles.
- R9: When a load/use hazard and a return in progress coincide, only the load/use actions apply: decode stalls and takes no bubble.
- R10: The memory bubble and write-back stall outputs stay at 0. Decode stall and decode bubble are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| f_cls_i | input | 3 | Class of the fetched instruction |
| f_src_a_i | input | REG_W | Fetched source A register ID |
| f_src_b_i | input | REG_W | Fetched source B register ID |
| f_dst_m_i | input | REG_W | Fetched load destination ID |
| f_tag_i | input | TAG_W | Identifying tag of the fetched instruction |
| e_cnd_i | input | 1 | Branch condition result for the execute instruction |
| f_stall_o | output | 1 | Fetch must hold its current instruction |
| d_stall_o | output | 1 | Decode register holds |
| d_bubble_o | output | 1 | Decode register loads a nop |
| e_bubble_o | output | 1 | Execute register loads a nop |
| m_bubble_o | output | 1 | Memory register loads a nop |
| w_stall_o | output | 1 | Write-back register holds |
| d_tag_o | output | TAG_W | Tag held in decode |
| e_tag_o | output | TAG_W | Tag held in execute |
| m_tag_o | output | TAG_W | Tag held in memory |
| w_tag_o | output | TAG_W | Tag held in write-back |

## Verification
The hardest case to reach is the overlap of a load/use hazard with a return. It needs a load in execute whose destination matches a source of a return that has just entered decode. This only happens when the load and the return are fetched back to back and no earlier stall has separated them. A directed program builds exactly that pair and counts the stall and bubble cycles that follow. A long arithmetic sweep then draws register IDs from a set of three real IDs plus "no register", so that matches, non-matches and back-to-back hazards of every class occur often. A bench model of the stage contents is compared with all tags and modes every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int unsigned REG_W = 4;
  parameter int unsigned TAG_W = 8;
  parameter int unsigned NSTG  = 4;

  localparam logic [REG_W-1:0] NO_REG = '1;

  typedef enum logic [2:0] {
    CLS_NOP   = 3'd0,
    CLS_ALU   = 3'd1,
    CLS_LOAD  = 3'd2,
    CLS_POP   = 3'd3,
    CLS_JUMP  = 3'd4,
    CLS_RET   = 3'd5,
    CLS_STORE = 3'd6,
    CLS_CALL  = 3'd7
  } iclass_e;

  // stage index of each pipeline register
  localparam int unsigned STG_D = 0;
  localparam int unsigned STG_E = 1;
  localparam int unsigned STG_M = 2;
  localparam int unsigned STG_W = 3;

  typedef struct packed {
    iclass_e          cls;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst_m;
    logic [TAG_W-1:0] tag;
  } slot_t;

  localparam int unsigned SLOT_W = $bits(slot_t);

  localparam slot_t NOP_SLOT = '{
    cls:   CLS_NOP,
    src_a: NO_REG,
    src_b: NO_REG,
    dst_m: NO_REG,
    tag:   '0
  };

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LOAD_USE,
    ACT_MISPRED,
    ACT_RET,
    ACT_MISPRED_RET
  } act_e;
endpackage

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg #(
  parameter int unsigned    W       = 8,
  parameter logic [W-1:0]   NOP_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stall_i,
  input  logic         bubble_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // bubble wins over stall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= NOP_VAL;
    else if (bubble_i) q_o <= NOP_VAL;
    else if (!stall_i) q_o <= d_i;
  end
endmodule

// File: rtl/hazard_detect.sv
module hazard_detect
  import hz_pkg::*;
(
  input  slot_t d_slot_i,
  input  slot_t e_slot_i,
  input  slot_t m_slot_i,
  input  logic  e_cnd_i,
  output logic  load_use_o,
  output logic  mispred_o,
  output logic  ret_busy_o
);
  logic e_is_load;
  logic src_hit;

  always_comb begin
    e_is_load  = (e_slot_i.cls == CLS_LOAD) || (e_slot_i.cls == CLS_POP);
    src_hit    = (e_slot_i.dst_m != NO_REG) &&
                 ((e_slot_i.dst_m == d_slot_i.src_a) ||
                  (e_slot_i.dst_m == d_slot_i.src_b));
    load_use_o = e_is_load && src_hit;
    mispred_o  = (e_slot_i.cls == CLS_JUMP) && !e_cnd_i;
    ret_busy_o = (d_slot_i.cls == CLS_RET) || (e_slot_i.cls == CLS_RET) ||
                 (m_slot_i.cls == CLS_RET);
  end
endmodule

// File: rtl/stage_mode_ctl.sv
module stage_mode_ctl
  import hz_pkg::*;
(
  input  logic            load_use_i,
  input  logic            mispred_i,
  input  logic            ret_busy_i,
  output logic            f_stall_o,
  output logic [NSTG-1:0] stall_o,
  output logic [NSTG-1:0] bubble_o
);
  act_e act;

  // load/use outranks return; jump and load cannot share execute
  always_comb begin
    if (load_use_i)                  act = ACT_LOAD_USE;
    else if (mispred_i && ret_busy_i) act = ACT_MISPRED_RET;
    else if (mispred_i)              act = ACT_MISPRED;
    else if (ret_busy_i)             act = ACT_RET;
    else                             act = ACT_NONE;
  end

  always_comb begin
    f_stall_o = 1'b0;
    stall_o   = '0;
    bubble_o  = '0;
    unique case (act)
      ACT_LOAD_USE: begin
        f_stall_o       = 1'b1;
        stall_o[STG_D]  = 1'b1;
        bubble_o[STG_E] = 1'b1;
      end
      ACT_MISPRED: begin
        bubble_o[STG_D] = 1'b1;
        bubble_o[STG_E] = 1'b1;
      end
      ACT_RET: begin
        f_stall_o       = 1'b1;
        bubble_o[STG_D] = 1'b1;
      end
      ACT_MISPRED_RET: begin
        f_stall_o       = 1'b1;
        bubble_o[STG_D] = 1'b1;
        bubble_o[STG_E] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hazard_ctl_top.sv
module hazard_ctl_top
  import hz_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       f_cls_i,
  input  logic [REG_W-1:0] f_src_a_i,
  input  logic [REG_W-1:0] f_src_b_i,
  input  logic [REG_W-1:0] f_dst_m_i,
  input  logic [TAG_W-1:0] f_tag_i,
  input  logic             e_cnd_i,
  output logic             f_stall_o,
  output logic             d_stall_o,
  output logic             d_bubble_o,
  output logic             e_bubble_o,
  output logic             m_bubble_o,
  output logic             w_stall_o,
  output logic [TAG_W-1:0] d_tag_o,
  output logic [TAG_W-1:0] e_tag_o,
  output logic [TAG_W-1:0] m_tag_o,
  output logic [TAG_W-1:0] w_tag_o
);
  slot_t           fetch_slot;
  slot_t           stg_in [NSTG];
  slot_t           stg_q  [NSTG];
  logic [NSTG-1:0] stall_v;
  logic [NSTG-1:0] bubble_v;
  logic            load_use;
  logic            mispred;
  logic            ret_busy;
  logic [2:0]      d_cls;
  logic [2:0]      e_cls;
  logic [2:0]      m_cls;

  always_comb begin
    fetch_slot.cls   = iclass_e'(f_cls_i);
    fetch_slot.src_a = f_src_a_i;
    fetch_slot.src_b = f_src_b_i;
    fetch_slot.dst_m = f_dst_m_i;
    fetch_slot.tag   = f_tag_i;
  end

  for (genvar gi = 0; gi < NSTG; gi++) begin : g_stg
    if (gi == 0) begin : g_head
      assign stg_in[gi] = fetch_slot;
    end else begin : g_body
      assign stg_in[gi] = stg_q[gi-1];
    end
    pipe_stage_reg #(
      .W      (SLOT_W),
      .NOP_VAL(NOP_SLOT)
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stall_i (stall_v[gi]),
      .bubble_i(bubble_v[gi]),
      .d_i     (stg_in[gi]),
      .q_o     (stg_q[gi])
    );
  end

  hazard_detect u_det (
    .d_slot_i  (stg_q[STG_D]),
    .e_slot_i  (stg_q[STG_E]),
    .m_slot_i  (stg_q[STG_M]),
    .e_cnd_i   (e_cnd_i),
    .load_use_o(load_use),
    .mispred_o (mispred),
    .ret_busy_o(ret_busy)
  );

  stage_mode_ctl u_mode (
    .load_use_i(load_use),
    .mispred_i (mispred),
    .ret_busy_i(ret_busy),
    .f_stall_o (f_stall_o),
    .stall_o   (stall_v),
    .bubble_o  (bubble_v)
  );

  assign d_stall_o  = stall_v[STG_D];
  assign d_bubble_o = bubble_v[STG_D];
  assign e_bubble_o = bubble_v[STG_E];
  assign m_bubble_o = bubble_v[STG_M];
  assign w_stall_o  = stall_v[STG_W];

  assign d_tag_o = stg_q[STG_D].tag;
  assign e_tag_o = stg_q[STG_E].tag;
  assign m_tag_o = stg_q[STG_M].tag;
  assign w_tag_o = stg_q[STG_W].tag;

  assign d_cls = stg_q[STG_D].cls;
  assign e_cls = stg_q[STG_E].cls;
  assign m_cls = stg_q[STG_M].cls;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk
  import hz_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TAG_W-1:0] f_tag_i,
  input logic             e_cnd_i,
  input logic             f_stall_o,
  input logic             d_stall_o,
  input logic             d_bubble_o,
  input logic             e_bubble_o,
  input logic             m_bubble_o,
  input logic             w_stall_o,
  input logic [TAG_W-1:0] d_tag_o,
  input logic [TAG_W-1:0] e_tag_o,
  input logic [2:0]       d_cls,
  input logic [2:0]       e_cls,
  input logic [2:0]       m_cls
);
  // R2
  d_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!d_stall_o && !d_bubble_o) |=> (d_tag_o == $past(f_tag_i)));

  // R2
  e_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !e_bubble_o |=> (e_tag_o == $past(d_tag_o)));

  // R4
  d_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_stall_o |=> $stable(d_tag_o));

  // R4
  e_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_bubble_o |=> (e_cls == CLS_NOP));

  // R6
  d_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_bubble_o |=> (d_cls == CLS_NOP));

  // R5
  mispred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_cls == CLS_JUMP && !e_cnd_i) |-> (d_bubble_o && e_bubble_o));

  // R7
  ret_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_cls == CLS_RET || e_cls == CLS_RET || m_cls == CLS_RET) |-> f_stall_o);

  // R10
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(d_stall_o && d_bubble_o));

  // R10
  tail_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_bubble_o && !w_stall_o);
endmodule

bind hazard_ctl_top hazard_ctl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .f_tag_i   (f_tag_i),
  .e_cnd_i   (e_cnd_i),
  .f_stall_o (f_stall_o),
  .d_stall_o (d_stall_o),
  .d_bubble_o(d_bubble_o),
  .e_bubble_o(e_bubble_o),
  .m_bubble_o(m_bubble_o),
  .w_stall_o (w_stall_o),
  .d_tag_o   (d_tag_o),
  .e_tag_o   (e_tag_o),
  .d_cls     (d_cls),
  .e_cls     (e_cls),
  .m_cls     (m_cls)
);

// File: tb/sim_hazard_ctl_top.sv
`timescale 1ns/1ps
module sim_hazard_ctl_top;
  import hz_pkg::*;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       f_cls = '0;
  logic [REG_W-1:0] f_sa = '1, f_sb = '1, f_dm = '1;
  logic [TAG_W-1:0] f_tag = '0;
  logic             e_cnd = 1'b0;
  logic             f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall;
  logic [TAG_W-1:0] d_tag, e_tag, m_tag, w_tag;

  always #2.5 clk = ~clk;

  hazard_ctl_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .f_cls_i(f_cls), .f_src_a_i(f_sa),
    .f_src_b_i(f_sb), .f_dst_m_i(f_dm), .f_tag_i(f_tag), .e_cnd_i(e_cnd),
    .f_stall_o(f_stall), .d_stall_o(d_stall), .d_bubble_o(d_bubble),
    .e_bubble_o(e_bubble), .m_bubble_o(m_bubble), .w_stall_o(w_stall),
    .d_tag_o(d_tag), .e_tag_o(e_tag), .m_tag_o(m_tag), .w_tag_o(w_tag)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  int cnd_mode = 0, seed = 0;
  int p_cls[64], p_sa[64], p_sb[64], p_dm[64];
  int mc[4], ma[4], mb[4], mdm[4], mt[4];
  int n_fst, n_dst, n_dbub, n_ebub;
  bit seen_w[256];
  bit combo_seen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_nop();
    for (int s = 0; s < 4; s++) begin
      mc[s] = 0; ma[s] = 15; mb[s] = 15; mdm[s] = 15; mt[s] = 0;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    model_nop();
  endtask

  task automatic filler();
    for (int i = 0; i < 64; i++) begin
      p_cls[i] = 1; p_sa[i] = 15; p_sb[i] = 15; p_dm[i] = 15;
    end
  endtask

  function automatic int pick(input int k);
    case (k % 4)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 15;
    endcase
  endfunction

  // runs ncyc cycles from a negedge, program length 64
  task automatic run(input int ncyc);
    int pc = 0;
    n_fst = 0; n_dst = 0; n_dbub = 0; n_ebub = 0;
    for (int i = 0; i < 256; i++) seen_w[i] = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      int ix, lu, mp, rb;
      int xf, xds, xdb, xeb;
      int nc[4], na[4], nb[4], nd[4], nt[4];
      ix = (pc < 64) ? pc : 63;
      f_cls = 3'(p_cls[ix]); f_sa = 4'(p_sa[ix]); f_sb = 4'(p_sb[ix]);
      f_dm = 4'(p_dm[ix]); f_tag = 8'((pc % 250) + 1);
      case (cnd_mode)
        0: e_cnd = 1'b0;
        1: e_cnd = 1'b1;
        default: e_cnd = 1'(((cyc * 3 + seed) >> 1) & 1);
      endcase
      #1;
      // R2 stage contents
      chk(d_tag == 8'(mt[0]), "R2 d_tag", d_tag, mt[0]);
      chk(e_tag == 8'(mt[1]), "R2 e_tag", e_tag, mt[1]);
      chk(m_tag == 8'(mt[2]), "R2 m_tag", m_tag, mt[2]);
      chk(w_tag == 8'(mt[3]), "R2 w_tag", w_tag, mt[3]);
      seen_w[w_tag] = 1'b1;
      lu = ((mc[1] == 2 || mc[1] == 3) && mdm[1] != 15 &&
            (mdm[1] == ma[0] || mdm[1] == mb[0])) ? 1 : 0;
      mp = (mc[1] == 4 && !e_cnd) ? 1 : 0;
      rb = (mc[0] == 5 || mc[1] == 5 || mc[2] == 5) ? 1 : 0;
      if (lu && rb) combo_seen = 1'b1;
      xf  = (lu || rb) ? 1 : 0;
      xds = lu;
      xdb = (mp || (rb && !lu)) ? 1 : 0;
      xeb = (mp || lu) ? 1 : 0;
      chk(f_stall == 1'(xf), "R8 f_stall", f_stall, xf);
      chk(d_stall == 1'(xds), "R4 d_stall", d_stall, xds);
      chk(d_bubble == 1'(xdb), "R6 d_bubble", d_bubble, xdb);
      chk(e_bubble == 1'(xeb), "R4 e_bubble", e_bubble, xeb);
      chk(!m_bubble && !w_stall, "R10 tail modes", {m_bubble, w_stall}, 0);
      n_fst += xf; n_dst += xds; n_dbub += xdb; n_ebub += xeb;
      // next state
      for (int s = 0; s < 4; s++) begin
        nc[s] = mc[s]; na[s] = ma[s]; nb[s] = mb[s]; nd[s] = mdm[s]; nt[s] = mt[s];
      end
      if (xdb) begin
        nc[0] = 0; na[0] = 15; nb[0] = 15; nd[0] = 15; nt[0] = 0;
      end else if (!xds) begin
        nc[0] = p_cls[ix]; na[0] = p_sa[ix]; nb[0] = p_sb[ix]; nd[0] = p_dm[ix];
        nt[0] = (pc % 250) + 1;
      end
      if (xeb) begin
        nc[1] = 0; na[1] = 15; nb[1] = 15; nd[1] = 15; nt[1] = 0;
      end else begin
        nc[1] = mc[0]; na[1] = ma[0]; nb[1] = mb[0]; nd[1] = mdm[0]; nt[1] = mt[0];
      end
      nc[2] = mc[1]; na[2] = ma[1]; nb[2] = mb[1]; nd[2] = mdm[1]; nt[2] = mt[1];
      nc[3] = mc[2]; na[3] = ma[2]; nb[3] = mb[2]; nd[3] = mdm[2]; nt[3] = mt[2];
      for (int s = 0; s < 4; s++) begin
        mc[s] = nc[s]; ma[s] = na[s]; mb[s] = nb[s]; mdm[s] = nd[s]; mt[s] = nt[s];
      end
      if (!xf) pc++;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_nop();
    @(negedge clk);
    #1;
    // R1 during reset
    chk({d_tag, e_tag, m_tag, w_tag} == '0, "R1 tags in reset", d_tag, 0);
    chk({f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall} == '0,
        "R1 modes in reset", f_stall, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk({d_tag, e_tag, m_tag, w_tag} == '0, "R1 tags after reset", w_tag, 0);
    chk(!f_stall && !d_bubble && !e_bubble, "R1 modes after reset", d_bubble, 0);
    @(negedge clk);

    // R7 R8 isolated return
    do_reset(); filler(); cnd_mode = 1;
    p_cls[0] = 5;
    run(12);
    chk(n_fst == 3, "R8 ret fetch stall cycles", n_fst, 3);
    chk(n_dbub == 3, "R7 ret decode bubbles", n_dbub, 3);
    chk(seen_w[2], "R8 instr after ret reaches W", seen_w[2], 1);

    // R3 R4 load/use on source A
    do_reset(); filler();
    p_cls[0] = 2; p_dm[0] = 1; p_sa[1] = 1;
    run(10);
    chk(n_dst == 1, "R4 load/use stall on src A", n_dst, 1);
    chk(n_ebub == 1, "R4 load/use execute bubble", n_ebub, 1);

    // R3 pop with source B match
    do_reset(); filler();
    p_cls[0] = 3; p_dm[0] = 2; p_sb[1] = 2;
    run(10);
    chk(n_dst == 1, "R3 pop match on src B", n_dst, 1);

    // R3 no-register ID never matches
    do_reset(); filler();
    p_cls[0] = 2; p_dm[0] = 15; p_sa[1] = 15;
    run(10);
    chk(n_dst == 0, "R3 no-register ID ignored", n_dst, 0);

    // R3 non-load with matching destination
    do_reset(); filler();
    p_cls[0] = 1; p_dm[0] = 0; p_sa[1] = 0;
    run(10);
    chk(n_dst == 0, "R3 non-load class ignored", n_dst, 0);

    // R5 R6 mispredicted jump
    do_reset(); filler(); cnd_mode = 0;
    p_cls[0] = 4;
    run(12);
    chk(!seen_w[2] && !seen_w[3], "R6 two squashed instrs", {seen_w[2], seen_w[3]}, 0);
    chk(seen_w[4], "R6 fall-through reaches W", seen_w[4], 1);
    chk(n_fst == 0, "R6 no fetch stall", n_fst, 0);

    // R5 taken jump has no action
    do_reset(); filler(); cnd_mode = 1;
    p_cls[0] = 4;
    run(12);
    chk(seen_w[2] && seen_w[3], "R5 taken jump keeps instrs", {seen_w[2], seen_w[3]}, 3);
    chk(n_dbub == 0, "R5 taken jump no bubble", n_dbub, 0);

    // R9 load/use plus return
    do_reset(); filler();
    p_cls[0] = 2; p_dm[0] = 1; p_cls[1] = 5; p_sa[1] = 1;
    combo_seen = 1'b0;
    run(14);
    chk(combo_seen, "R9 combination reached", combo_seen, 1);
    chk(n_fst == 4, "R9 fetch stall cycles", n_fst, 4);
    chk(n_dst == 1, "R9 decode stall cycles", n_dst, 1);
    chk(n_dbub == 3, "R9 decode bubbles", n_dbub, 3);

    // R10 and all: arithmetic sweep
    cnd_mode = 2;
    for (int r = 0; r < 40; r++) begin
      do_reset();
      seed = r;
      for (int i = 0; i < 64; i++) begin
        int h;
        h = i * 13 + r * 7 + (i * r) % 5 + (i / 3) * 11;
        p_cls[i] = h % 8;
        p_sa[i]  = pick(h / 8);
        p_sb[i]  = pick(h / 32 + i);
        p_dm[i]  = (p_cls[i] == 2 || p_cls[i] == 3) ? (h / 3) % 3 : pick(h / 5);
      end
      run(90);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule